// File: doc/BRIEF.md
# Saturating Lane Bus with Per-Domain Pattern Winner

This block merges the write-phase outputs of a field of tiles into one small output bus and picks a single winning tile for a chosen domain. Every tile presents an eight-lane vector of 4-bit levels. A tile takes part in the bus only when it may write to the bus and it is locked, either by its own lock or through a locked ancestor. Each output lane carries the sum of all enabled contributions on that lane. The sum is clamped at the top level value 15, so several weak tiles add up and strong ones saturate. No tile is muxed onto the bus.

Every tile also carries a 4-bit domain number and an 8-bit priority. Its index is its tile id. Among the tiles that hold their own lock in the selected domain, the tile with the highest priority wins, and the lower index wins a tie. The block reports the winner's id, a valid bit and a collision bit. When auto-reset is enabled, it also gives a one-hot reset mask that points at the domain that produced the winner.

All results are combinational inside the block and are captured into the output registers only on a clock edge where the readout strobe is high. The registered outputs then stay steady for the host to read.

Top module: `lane_sum_arbiter`

## Requirements
- R1: Each lane of `bus_o` (lane k in bits 4k+3..4k) equals min(15, sum of lane k of `drive_i` over all enabled tiles). The sum never wraps, even when every tile drives 15.
- R2: Tile t is enabled for the bus exactly when `bus_w_i[t]` is 1 and at least one of `locked_i[t]` or `anc_locked_i[t]` is 1. A tile with `bus_w_i` at 0 adds nothing, whatever its lock state.
- R3: A tile is a candidate when `locked_i[t]` is 1 and its domain `dom_i[t]` equals `sel_dom_i`. A lock that comes only from an ancestor does not make a tile a candidate. `pattern_id_o` is the index of the candidate with the highest `prio_i` value, compared as unsigned.
- R4: When several candidates share the highest priority, the one with the smallest index wins.
- R5: `collide_o` is 1 exactly when two or more candidates exist.
- R6: With no candidate, `win_valid_o` is 0 and `pattern_id_o` is all ones. Otherwise `win_valid_o` is 1.
- R7: `rst_mask_o` has bit `sel_dom_i` set, and no other bit, when `auto_rst_en_i` is 1 and a winner exists. In every other case it is all zero.
- R8: The outputs take their new values at a rising clock edge where `sample_i` is 1. At any other edge they keep their values.
- R9: While `rst_ni` is low, `bus_o`, `win_valid_o`, `collide_o` and `rst_mask_o` are 0, and `pattern_id_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Readout strobe; the outputs load on this edge |
| bus_w_i | input | N_TILES | Per-tile permission to write to the bus |
| locked_i | input | N_TILES | Per-tile own lock |
| anc_locked_i | input | N_TILES | Per-tile locked-ancestor indication |
| drive_i | input | N_TILES*LANES*4 | Per-tile lane levels; tile t, lane k at bits (t*LANES+k)*4 +: 4 |
| dom_i | input | N_TILES*4 | Per-tile domain number |
| prio_i | input | N_TILES*8 | Per-tile priority |
| sel_dom_i | input | 4 | Domain that is arbitrated |
| auto_rst_en_i | input | 1 | Enables the winner-domain reset mask |
| bus_o | output | LANES*4 | Clamped lane sums |
| pattern_id_o | output | ID_W | Winning tile index |
| win_valid_o | output | 1 | A winner exists |
| collide_o | output | 1 | Two or more candidates exist |
| rst_mask_o | output | N_DOM | One-hot reset mask for the winner's domain |

## Verification
A wrong adder width or a wrong clamp shows up as a lane value that is low or wrapped. It appears at the first readout edge where many tiles drive high levels. An error in the enable term appears as a lane value that moves when only bus permission or ancestor lock is toggled. A fault in the priority compare or in the tie order gives the wrong id at the very next sampled edge. Because the outputs are registered, a bad hold appears one edge after a cycle with the strobe low, as an output that changes while the inputs were changed on purpose.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  function automatic int unsigned width_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lane_adder.sv
module lane_adder #(
  parameter int unsigned N_TILES = 8
) (
  input  logic [N_TILES-1:0]                    en_i,
  input  logic [N_TILES-1:0][lsa_pkg::LVL_W-1:0] lvl_i,
  output logic [lsa_pkg::LVL_W-1:0]             sat_o
);
  localparam int unsigned SUM_W = lsa_pkg::LVL_W + $clog2(N_TILES + 1);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int t = 0; t < N_TILES; t++)
      if (en_i[t]) sum = sum + SUM_W'(lvl_i[t]);
  end

  assign sat_o = (sum > SUM_W'(lsa_pkg::LVL_MAX)) ? lsa_pkg::LVL_W'(lsa_pkg::LVL_MAX)
                                                 : sum[lsa_pkg::LVL_W-1:0];
endmodule

// File: rtl/domain_arbiter.sv
module domain_arbiter #(
  parameter int unsigned N_TILES = 8,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned DOM_W   = 4,
  localparam int unsigned ID_W   = lsa_pkg::width_of(N_TILES)
) (
  input  logic [N_TILES-1:0]             locked_i,
  input  logic [N_TILES-1:0][DOM_W-1:0]  dom_i,
  input  logic [N_TILES-1:0][PRIO_W-1:0] prio_i,
  input  logic [DOM_W-1:0]               sel_dom_i,
  output logic [ID_W-1:0]                win_id_o,
  output logic                           win_valid_o,
  output logic                           collide_o
);
  logic [PRIO_W-1:0] best_prio;
  logic              seen_two;

  // ascending scan with strict compare keeps the lowest index on a tie
  always_comb begin
    win_id_o    = '1;
    win_valid_o = 1'b0;
    seen_two    = 1'b0;
    best_prio   = '0;
    for (int t = 0; t < N_TILES; t++) begin
      if (locked_i[t] && dom_i[t] == sel_dom_i) begin
        if (win_valid_o) seen_two = 1'b1;
        if (!win_valid_o || prio_i[t] > best_prio) begin
          best_prio = prio_i[t];
          win_id_o  = ID_W'(t);
        end
        win_valid_o = 1'b1;
      end
    end
    collide_o = seen_two;
  end
endmodule

// File: rtl/lane_sum_arbiter.sv
module lane_sum_arbiter #(
  parameter int unsigned N_TILES = 8,
  parameter int unsigned LANES   = 8,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned DOM_W   = 4,
  localparam int unsigned N_DOM  = 1 << DOM_W,
  localparam int unsigned LVL_W  = lsa_pkg::LVL_W,
  localparam int unsigned ID_W   = lsa_pkg::width_of(N_TILES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sample_i,
  input  logic [N_TILES-1:0]             bus_w_i,
  input  logic [N_TILES-1:0]             locked_i,
  input  logic [N_TILES-1:0]             anc_locked_i,
  input  logic [N_TILES*LANES*LVL_W-1:0] drive_i,
  input  logic [N_TILES*DOM_W-1:0]       dom_i,
  input  logic [N_TILES*PRIO_W-1:0]      prio_i,
  input  logic [DOM_W-1:0]               sel_dom_i,
  input  logic                           auto_rst_en_i,
  output logic [LANES*LVL_W-1:0]         bus_o,
  output logic [ID_W-1:0]                pattern_id_o,
  output logic                           win_valid_o,
  output logic                           collide_o,
  output logic [N_DOM-1:0]               rst_mask_o
);
  logic [N_TILES-1:0]             drv_en;
  logic [LANES-1:0][LVL_W-1:0]    lane_sat;
  logic [N_TILES-1:0][DOM_W-1:0]  dom_v;
  logic [N_TILES-1:0][PRIO_W-1:0] prio_v;
  logic [ID_W-1:0]                win_id;
  logic                           win_valid, collide;
  logic [N_DOM-1:0]               mask_d;

  assign drv_en = bus_w_i & (locked_i | anc_locked_i);

  for (genvar t = 0; t < N_TILES; t++) begin : g_unpack
    assign dom_v[t]  = dom_i[t*DOM_W +: DOM_W];
    assign prio_v[t] = prio_i[t*PRIO_W +: PRIO_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [N_TILES-1:0][LVL_W-1:0] lane_in;
    for (genvar t = 0; t < N_TILES; t++) begin : g_pick
      assign lane_in[t] = drive_i[(t*LANES+k)*LVL_W +: LVL_W];
    end
    lane_adder #(.N_TILES(N_TILES)) u_add (
      .en_i (drv_en),
      .lvl_i(lane_in),
      .sat_o(lane_sat[k])
    );
  end

  domain_arbiter #(
    .N_TILES(N_TILES), .PRIO_W(PRIO_W), .DOM_W(DOM_W)
  ) u_arb (
    .locked_i   (locked_i),
    .dom_i      (dom_v),
    .prio_i     (prio_v),
    .sel_dom_i  (sel_dom_i),
    .win_id_o   (win_id),
    .win_valid_o(win_valid),
    .collide_o  (collide)
  );

  always_comb begin
    mask_d = '0;
    if (auto_rst_en_i && win_valid) mask_d[sel_dom_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o        <= '0;
      pattern_id_o <= '1;
      win_valid_o  <= 1'b0;
      collide_o    <= 1'b0;
      rst_mask_o   <= '0;
    end else if (sample_i) begin
      bus_o        <= lane_sat;
      pattern_id_o <= win_id;
      win_valid_o  <= win_valid;
      collide_o    <= collide;
      rst_mask_o   <= mask_d;
    end
  end
endmodule

// File: rtl/lsa_chk.sv
module lsa_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned DOM_W = 4,
  localparam int unsigned N_DOM = 1 << DOM_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sample_i,
  input logic [LANES*4-1:0]     bus_o,
  input logic [ID_W-1:0]        pattern_id_o,
  input logic                   win_valid_o,
  input logic                   collide_o,
  input logic [N_DOM-1:0]       rst_mask_o
);
  // R6
  no_win_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_valid_o |-> pattern_id_o == '1);
  // R5
  collide_needs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |-> win_valid_o);
  // R7
  mask_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rst_mask_o));
  // R7
  mask_needs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rst_mask_o) |-> win_valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(bus_o) && $stable(pattern_id_o) && $stable(win_valid_o)
                  && $stable(collide_o) && $stable(rst_mask_o));
endmodule

bind lane_sum_arbiter lsa_chk #(.LANES(LANES), .ID_W(ID_W), .DOM_W(DOM_W)) u_lsa_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .bus_o       (bus_o),
  .pattern_id_o(pattern_id_o),
  .win_valid_o (win_valid_o),
  .collide_o   (collide_o),
  .rst_mask_o  (rst_mask_o)
);

// File: tb/tb_lane_sum_arbiter.sv
module tb_lane_sum_arbiter;
  localparam int NT = 8;
  localparam int NL = 8;
  localparam int IDW = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0, sample = 0, arst_en = 0;
  logic [NT-1:0] bus_w = '0, locked = '0, anc = '0;
  logic [NT*NL*4-1:0] drive = '0;
  logic [NT*4-1:0] dom = '0;
  logic [NT*8-1:0] prio = '0;
  logic [3:0] sel = '0;
  logic [NL*4-1:0] bus;
  logic [IDW-1:0] pid;
  logic valid, coll;
  logic [15:0] mask;

  logic [NL*4-1:0] e_bus = '0;
  logic [IDW-1:0] e_pid = '1;
  logic e_valid = 0, e_coll = 0;
  logic [15:0] e_mask = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sum_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample), .bus_w_i(bus_w),
    .locked_i(locked), .anc_locked_i(anc), .drive_i(drive), .dom_i(dom),
    .prio_i(prio), .sel_dom_i(sel), .auto_rst_en_i(arst_en),
    .bus_o(bus), .pattern_id_o(pid), .win_valid_o(valid),
    .collide_o(coll), .rst_mask_o(mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    int n, best, bp;
    for (int k = 0; k < NL; k++) begin
      int s = 0;
      for (int t = 0; t < NT; t++)
        if (bus_w[t] && (locked[t] || anc[t])) s += drive[(t*NL+k)*4 +: 4];
      e_bus[k*4 +: 4] = (s > 15) ? 4'd15 : 4'(s);
    end
    n = 0; best = -1; bp = -1;
    for (int t = 0; t < NT; t++)
      if (locked[t] && dom[t*4 +: 4] == sel) begin
        n++;
        if (int'(prio[t*8 +: 8]) > bp) begin bp = prio[t*8 +: 8]; best = t; end
      end
    e_valid = (n > 0);
    e_coll  = (n > 1);
    e_pid   = (n > 0) ? IDW'(best) : '1;
    e_mask  = '0;
    if (arst_en && n > 0) e_mask[sel] = 1'b1;
  endtask

  task automatic compare();
    chk("R1/R2 bus", 64'(bus), 64'(e_bus));
    chk("R3/R4 pattern_id", 64'(pid), 64'(e_pid));
    chk("R6 valid", 64'(valid), 64'(e_valid));
    chk("R5 collide", 64'(coll), 64'(e_coll));
    chk("R7 mask", 64'(mask), 64'(e_mask));
  endtask

  // inputs already set; clock one edge and compare after it
  task automatic step();
    @(posedge clk);
    if (sample) model();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic set_tile(input int t, input bit bw, input bit lk, input bit an,
                          input logic [3:0] lvl, input logic [3:0] d, input logic [7:0] p);
    bus_w[t] = bw; locked[t] = lk; anc[t] = an;
    for (int k = 0; k < NL; k++) drive[(t*NL+k)*4 +: 4] = lvl;
    dom[t*4 +: 4] = d; prio[t*8 +: 8] = p;
  endtask

  task automatic clear();
    bus_w = '0; locked = '0; anc = '0; drive = '0; dom = '0; prio = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset values
    #(CLK_PERIOD*2 + 1);
    compare();
    @(negedge clk); rst_ni = 1;
    sample = 1;

    // R1 saturation: all tiles drive 15 on every lane
    for (int t = 0; t < NT; t++) set_tile(t, 1, 1, 0, 4'd15, 4'd2, 8'd9);
    sel = 4'd2; step();

    // R1 unsaturated sum: 2+3+4 = 9
    clear();
    set_tile(0, 1, 1, 0, 4'd2, 4'd0, 8'd0);
    set_tile(3, 1, 0, 1, 4'd3, 4'd0, 8'd0);
    set_tile(5, 1, 1, 1, 4'd4, 4'd0, 8'd0);
    sel = 4'd0; step();

    // R2 bus_w=0 tiles add nothing; ancestor-only lock drives but is no candidate (R3)
    clear();
    set_tile(1, 0, 1, 1, 4'd7, 4'd4, 8'd200);
    set_tile(2, 1, 0, 1, 4'd5, 4'd4, 8'd250);
    set_tile(6, 1, 0, 0, 4'd5, 4'd4, 8'd1);
    sel = 4'd4; step();

    // R3 highest priority wins, R5 collide
    clear();
    set_tile(1, 1, 1, 0, 4'd1, 4'd7, 8'd10);
    set_tile(4, 1, 1, 0, 4'd1, 4'd7, 8'd90);
    set_tile(6, 1, 1, 0, 4'd1, 4'd3, 8'd255);
    sel = 4'd7; arst_en = 1; step();

    // R4 tie goes to lowest index
    clear();
    set_tile(2, 1, 1, 0, 4'd1, 4'd9, 8'd77);
    set_tile(5, 1, 1, 0, 4'd1, 4'd9, 8'd77);
    set_tile(7, 1, 1, 0, 4'd1, 4'd9, 8'd77);
    sel = 4'd9; step();

    // R6 no candidate in selected domain, R7 mask stays zero
    sel = 4'd10; step();

    // R8 hold: strobe low, inputs change, outputs keep values
    sel = 4'd9; step();
    sample = 0; clear();
    set_tile(0, 1, 1, 0, 4'd15, 4'd1, 8'd3);
    sel = 4'd1; step(); step();
    sample = 1; step();

    // random patterns, strobe toggles
    for (int i = 0; i < 400; i++) begin
      for (int t = 0; t < NT; t++)
        set_tile(t, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                 4'($urandom_range(0, 3)), 8'($urandom_range(0, 7)));
      for (int j = 0; j < NT*NL; j++) drive[j*4 +: 4] = 4'($urandom);
      sel = 4'($urandom_range(0, 3));
      arst_en = 1'($urandom);
      sample = ($urandom_range(0, 3) != 0);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule